// File: doc/BRIEF.md
# Sample Buffer Pointer and Length Controller

This block is the register unit that a host uses to stream bytes into and out of a 64 KiB sample buffer. The host programs a 16-bit address port one byte at a time. It then arms a read pointer or a write pointer from that port by raising a control bit. When a bit that picks an exact load is clear, the pointer is armed one position early. This lets the first access that increments the pointer land on the port address.

Single-byte accesses go through a data register. A host write to it queues one memory write. A host read of it returns the previously fetched byte and queues a fetch of the next one. The buffer memory sits behind an external slot scheduler. The block holds a request high until the scheduler answers with a one-cycle done pulse. On that pulse the block advances the pointer and updates a 17-bit length counter.

The length counter drives two level interrupts: one for half way and one for end of data. A latch mode makes the length follow the address port and holds it against completions. A clear bit returns the pointers, the length, the flags and any pending access to zero.

Top module: `adpcm_addr_ctrl`

## Requirements
- R1: A host write at offset 0x8 sets the low byte of the address port, and a host write at offset 0x9 sets its high byte. The port is not readable. It is seen through the pointer loads.
- R2: When control bit 1 goes from 0 to 1, the write pointer takes the address port value. It takes the port value minus one when control bit 0 is clear. The write pointer is always visible on `mem_wr_addr`.
- R3: When control bit 3 goes from 0 to 1, the read pointer takes the address port value. It takes the port value minus one when control bit 2 is clear. The read pointer is always visible on `mem_rd_addr`.
- R4: A host write at offset 0xA stores the byte on `mem_wr_data` and raises `mem_wr_req`. The request stays high until `mem_wr_done`, and status bit 2 mirrors it.
- R5: A host read at offset 0xA returns the byte from the last completed fetch (0 after reset) and raises `mem_rd_req`. The request stays high until `mem_rd_done`, which stores `mem_rd_data` as the new fetched byte. Status bit 7 mirrors the request.
- R6: A completed write increments the write pointer. If the length was zero it sets the end flag. It sets the half flag to (length < 0x8000), using the length before the update. Outside latch mode it then increments the length modulo 2^17.
- R7: A completed read increments the read pointer. Outside latch mode, a nonzero length is decremented and the half flag becomes (new length < 0x8000). A zero length instead sets the end flag and clears the half flag.
- R8: While control bit 4 is set, the length is reloaded from the address port on every cycle and the end flag is held clear. In this mode, completions change neither the length nor the end flag.
- R9: While control bit 7 is set, both pointers, the length, both flags and both pending requests are cleared. This takes effect from the cycle of the control write.
- R10: A read at offset 0xC returns the end flag in bit 0, the pending write in bit 2, the `playing` input in bit 3 and the pending read in bit 7. All other bits are zero.
- R11: Offset 0xD reads back the control byte. Offset 0xE is a read/write rate byte that also drives `rate_cfg`. Every other offset reads as 0.
- R12: `irq_half` is the half flag and `irq_end` is the end flag. Each changes only when its flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from offset |
| playing | input | 1 | Decoder playing indication, shown in status |
| rate_cfg | output | 8 | Rate register value |
| mem_wr_req | output | 1 | Pending buffer write |
| mem_wr_addr | output | 16 | Write pointer |
| mem_wr_data | output | 8 | Byte to write |
| mem_wr_done | input | 1 | Scheduler completed the write |
| mem_rd_req | output | 1 | Pending buffer fetch |
| mem_rd_addr | output | 16 | Read pointer |
| mem_rd_data | input | 8 | Fetched byte, valid with done |
| mem_rd_done | input | 1 | Scheduler completed the fetch |
| irq_half | output | 1 | Half-way interrupt level |
| irq_end | output | 1 | End-of-data interrupt level |

## Verification
The assertions assume that the scheduler pulses a done signal only while the matching request is high. They also assume that each pulse lasts a single cycle and that a host strobe never targets two offsets at once. The bench models the scheduler as a task that pulses done for exactly one cycle. It calls that task only after a request has been seen high. Host accesses are issued one per cycle, each followed by an idle cycle. Length-dependent flags are driven through chains of completions whose outcome is known from the requirements, since the length itself is not readable.

// File: rtl/adpcm_ctrl_pkg.sv
// Shared offsets and bit positions for the sample buffer pointer controller.
package adpcm_ctrl_pkg;
    localparam int REG_AW = 4;

    // Register offsets the host decodes
    localparam logic [REG_AW-1:0] OFS_PORT_LO = 4'h8;
    localparam logic [REG_AW-1:0] OFS_PORT_HI = 4'h9;
    localparam logic [REG_AW-1:0] OFS_DATA    = 4'hA;
    localparam logic [REG_AW-1:0] OFS_STATUS  = 4'hC;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 4'hD;
    localparam logic [REG_AW-1:0] OFS_RATE    = 4'hE;

    // Control bit positions
    localparam int CB_WR_EXACT = 0;
    localparam int CB_WR_ARM   = 1;
    localparam int CB_RD_EXACT = 2;
    localparam int CB_RD_ARM   = 3;
    localparam int CB_LATCH    = 4;
    localparam int CB_CLEAR    = 7;

    // Status bit positions
    localparam int SB_END   = 0;
    localparam int SB_WBUSY = 2;
    localparam int SB_PLAY  = 3;
    localparam int SB_RBUSY = 7;
endpackage

// File: rtl/adpcm_ptr_unit.sv
// Buffer pointer: loads from the address port (exact or one early) on an arm
// event, increments once per completed access, and is cleared by the clear bit.
// Assumes arm is a single-cycle event; clear outranks arm, arm outranks step.
module adpcm_ptr_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         arm,
    input  logic         exact,
    input  logic [W-1:0] port_val,
    input  logic         step,
    output logic [W-1:0] ptr
);
    // Pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (clr)   ptr <= '0;
        else if (arm)   ptr <= exact ? port_val : port_val - W'(1);
        else if (step)  ptr <= ptr + W'(1);
    end

    // R6
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !arm && !clr) |=> ptr == $past(ptr) + W'(1));

    // R2
    arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clr) |=> ptr == ($past(exact) ? $past(port_val) : $past(port_val) - W'(1)));
endmodule

// File: rtl/adpcm_len_tracker.sv
// Length counter with half-way and end flags. A read completion counts down,
// a write completion counts up; latch mode reloads from the port every cycle
// and holds end clear. Order within a cycle: read, write, latch, clear.
// Assumes done inputs are already qualified by their pending requests.
module adpcm_len_tracker #(
    parameter int PW = 16,
    localparam int LW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          latch,
    input  logic [PW-1:0] port_val,
    input  logic          rd_done,
    input  logic          wr_done,
    output logic          half_f,
    output logic          end_f
);
    localparam logic [LW-1:0] HALF_MARK = LW'(1) << (PW - 1);

    logic [LW-1:0] len_q, len_d;
    logic          half_d, end_d;

    // Next-state computation in the required order of effects
    always_comb begin
        len_d  = len_q;
        half_d = half_f;
        end_d  = end_f;
        if (rd_done && !latch) begin
            if (len_d != '0) begin
                len_d  = len_d - LW'(1);
                half_d = (len_d < HALF_MARK);
            end else begin
                end_d  = 1'b1;
                half_d = 1'b0;
            end
        end
        if (wr_done) begin
            if (len_d == '0) end_d = 1'b1;
            half_d = (len_d < HALF_MARK);
            if (!latch) len_d = len_d + LW'(1);
        end
        if (latch) begin
            len_d = {1'b0, port_val};
            end_d = 1'b0;
        end
        if (clr) begin
            len_d  = '0;
            half_d = 1'b0;
            end_d  = 1'b0;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            half_f <= 1'b0;
            end_f  <= 1'b0;
        end else begin
            len_q  <= len_d;
            half_f <= half_d;
            end_f  <= end_d;
        end
    end

    // R8
    latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && !clr) |=> (len_q == {1'b0, $past(port_val)}) && !end_f);

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (len_q == '0) && !end_f && !half_f);

    // R7
    read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !wr_done && !latch && !clr && len_q == '0) |=> end_f && !half_f);

    // R12
    end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_f) |-> $past(rd_done || wr_done));
endmodule

// File: rtl/adpcm_addr_ctrl.sv
// Host register unit for a sample buffer: address port, control, rate and
// status registers, a data register that queues single-byte accesses to an
// external slot scheduler, and the pointer and length state those accesses move.
// Assumes the scheduler pulses done for one cycle, only while its request is high.
module adpcm_addr_ctrl
    import adpcm_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PTR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              playing,
    output logic [DATA_W-1:0] rate_cfg,
    output logic              mem_wr_req,
    output logic [PTR_W-1:0]  mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_done,
    output logic              mem_rd_req,
    output logic [PTR_W-1:0]  mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_done,
    output logic              irq_half,
    output logic              irq_end
);
    logic [PTR_W-1:0]  port_q;
    logic [DATA_W-1:0] ctrl_q, ctrl_eff, rate_q, wbuf_q, rbuf_q;
    logic              wr_pend, rd_pend;
    logic              hit_lo, hit_hi, hit_ctrl, hit_rate, data_wr, data_rd;
    logic              clr, latch, wr_fire, rd_fire;
    logic              half_f, end_f;
    logic [1:0]        arm_vec, exact_vec, step_vec;
    logic [PTR_W-1:0]  ptr_vec [2];

    // Host strobe decode
    always_comb begin
        hit_lo   = reg_wr && (reg_addr == OFS_PORT_LO);
        hit_hi   = reg_wr && (reg_addr == OFS_PORT_HI);
        hit_ctrl = reg_wr && (reg_addr == OFS_CTRL);
        hit_rate = reg_wr && (reg_addr == OFS_RATE);
        data_wr  = reg_wr && (reg_addr == OFS_DATA);
        data_rd  = reg_rd && (reg_addr == OFS_DATA);
    end

    // Control value in force this cycle, including a write landing now
    always_comb begin
        ctrl_eff = hit_ctrl ? reg_wdata : ctrl_q;
        clr      = ctrl_eff[CB_CLEAR];
        latch    = ctrl_eff[CB_LATCH];
        wr_fire  = mem_wr_done && wr_pend;
        rd_fire  = mem_rd_done && rd_pend;
    end

    // Host-written registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            ctrl_q <= '0;
            rate_q <= '0;
            wbuf_q <= '0;
        end else begin
            if (hit_lo)   port_q[DATA_W-1:0]     <= reg_wdata;
            if (hit_hi)   port_q[PTR_W-1:DATA_W] <= reg_wdata;
            if (hit_ctrl) ctrl_q <= reg_wdata;
            if (hit_rate) rate_q <= reg_wdata;
            if (data_wr)  wbuf_q <= reg_wdata;
        end
    end

    // Pending write: raised by a data write, dropped on completion or clear
    always_ff @(posedge clk) begin
        if (!rst_n)        wr_pend <= 1'b0;
        else if (clr)      wr_pend <= 1'b0;
        else if (data_wr)  wr_pend <= 1'b1;
        else if (wr_fire)  wr_pend <= 1'b0;
    end

    // Pending fetch: raised by a data read, dropped on completion or clear
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_pend <= 1'b0;
        else if (clr)      rd_pend <= 1'b0;
        else if (data_rd)  rd_pend <= 1'b1;
        else if (rd_fire)  rd_pend <= 1'b0;
    end

    // Fetched byte buffer
    always_ff @(posedge clk) begin
        if (!rst_n)       rbuf_q <= '0;
        else if (rd_fire) rbuf_q <= mem_rd_data;
    end

    // Per-pointer arm, exact and step selection (index 0 = write, 1 = read)
    always_comb begin
        arm_vec[0]   = ctrl_eff[CB_WR_ARM] && !ctrl_q[CB_WR_ARM];
        arm_vec[1]   = ctrl_eff[CB_RD_ARM] && !ctrl_q[CB_RD_ARM];
        exact_vec[0] = ctrl_eff[CB_WR_EXACT];
        exact_vec[1] = ctrl_eff[CB_RD_EXACT];
        step_vec[0]  = wr_fire;
        step_vec[1]  = rd_fire;
    end

    for (genvar g = 0; g < 2; g++) begin : g_ptr
        adpcm_ptr_unit #(.W(PTR_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .arm      (arm_vec[g]),
            .exact    (exact_vec[g]),
            .port_val (port_q),
            .step     (step_vec[g]),
            .ptr      (ptr_vec[g])
        );
    end

    adpcm_len_tracker #(.PW(PTR_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .latch    (latch),
        .port_val (port_q),
        .rd_done  (rd_fire),
        .wr_done  (wr_fire),
        .half_f   (half_f),
        .end_f    (end_f)
    );

    // Host read data mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_DATA)   reg_rdata = rbuf_q;
        if (reg_addr == OFS_CTRL)   reg_rdata = ctrl_q;
        if (reg_addr == OFS_RATE)   reg_rdata = rate_q;
        if (reg_addr == OFS_STATUS) begin
            reg_rdata[SB_END]   = end_f;
            reg_rdata[SB_WBUSY] = wr_pend;
            reg_rdata[SB_PLAY]  = playing;
            reg_rdata[SB_RBUSY] = rd_pend;
        end
    end

    // Output drive
    always_comb begin
        mem_wr_req  = wr_pend;
        mem_rd_req  = rd_pend;
        mem_wr_addr = ptr_vec[0];
        mem_rd_addr = ptr_vec[1];
        mem_wr_data = wbuf_q;
        rate_cfg    = rate_q;
        irq_half    = half_f;
        irq_end     = end_f;
    end

    // R4
    wr_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_req) |-> $past(mem_wr_done) || $past(clr));

    // R5
    rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_req) |-> $past(mem_rd_done) || $past(clr));

    // R4
    wr_req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !clr) |=> mem_wr_req);

    // R9
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !mem_wr_req && !mem_rd_req && mem_wr_addr == '0 && mem_rd_addr == '0);
endmodule

// File: tb/adpcm_addr_ctrl_bench.sv
module adpcm_addr_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        playing = 1'b0;
    logic [7:0]  rate_cfg;
    logic        mem_wr_req, mem_rd_req;
    logic [15:0] mem_wr_addr, mem_rd_addr;
    logic [7:0]  mem_wr_data;
    logic        mem_wr_done = 1'b0, mem_rd_done = 1'b0;
    logic [7:0]  mem_rd_data = '0;
    logic        irq_half, irq_end;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       tag;
        logic [31:0] a;
        logic [31:0] b;
    } exp_t;

    exp_t rd_q[$];
    exp_t wr_q[$];
    event rd_ev, wr_ev;

    always #4 clk = ~clk;

    adpcm_addr_ctrl u_adpcm_addr_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .playing(playing), .rate_cfg(rate_cfg),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_done(mem_wr_done), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_done(mem_rd_done),
        .irq_half(irq_half), .irq_end(irq_end)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_model(logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    // Monitor: host read data against queued expectations
    always @(rd_ev) begin
        exp_t e;
        e = rd_q.pop_front();
        chk(e.tag, {24'h0, reg_rdata}, e.a);
    end

    // Monitor: memory write address and data at completion
    always @(wr_ev) begin
        exp_t e;
        e = wr_q.pop_front();
        chk({e.tag, " addr"}, {16'h0, mem_wr_addr}, e.a);
        chk({e.tag, " data"}, {24'h0, mem_wr_data}, e.b);
    end

    task automatic host_wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_rd(logic [3:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        rd_q.push_back('{tag, {24'h0, exp}, 0});
        #2 ->rd_ev;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic finish_wr(logic [15:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        chk({tag, " req"}, {31'h0, mem_wr_req}, 1);
        wr_q.push_back('{tag, {16'h0, a}, {24'h0, d}});
        mem_wr_done = 1'b1;
        #2 ->wr_ev;
        @(negedge clk);
        mem_wr_done = 1'b0;
    endtask

    task automatic finish_rd(logic [15:0] a, string tag);
        @(negedge clk);
        chk({tag, " req"}, {31'h0, mem_rd_req}, 1);
        chk({tag, " addr"}, {16'h0, mem_rd_addr}, {16'h0, a});
        mem_rd_data = mem_model(mem_rd_addr);
        mem_rd_done = 1'b1;
        @(negedge clk);
        mem_rd_done = 1'b0;
    endtask

    task automatic flags(logic h, logic e, string tag);
        chk({tag, " irq_half"}, {31'h0, irq_half}, {31'h0, h});
        chk({tag, " irq_end"}, {31'h0, irq_end}, {31'h0, e});
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R10, R12, R4, R5)
        host_rd(4'hC, 8'h00, "R10 reset status");
        flags(0, 0, "R12 reset");
        chk("R4 reset wr_req", {31'h0, mem_wr_req}, 0);
        chk("R5 reset rd_req", {31'h0, mem_rd_req}, 0);

        // R1 R2: port 0x1234, arm write pointer one early
        host_wr(4'h8, 8'h34);
        host_wr(4'h9, 8'h12);
        host_wr(4'hD, 8'h02);
        chk("R2 write ptr early", {16'h0, mem_wr_addr}, 32'h1233);
        host_wr(4'hA, 8'hA5);
        host_rd(4'hC, 8'h04, "R4 status busy");
        repeat (3) @(negedge clk);
        chk("R4 req held", {31'h0, mem_wr_req}, 1);
        finish_wr(16'h1233, 8'hA5, "R4 first write");
        // R6: length was zero
        flags(1, 1, "R6 write at zero");
        chk("R6 wptr step", {16'h0, mem_wr_addr}, 32'h1234);
        host_rd(4'hC, 8'h01, "R10 end only");

        // R3: arm read pointer exactly
        host_wr(4'hD, 8'h0E);
        host_rd(4'hD, 8'h0E, "R11 ctrl readback");
        chk("R3 read ptr exact", {16'h0, mem_rd_addr}, 32'h1234);
        host_rd(4'hA, 8'h00, "R5 first fetch byte");
        host_rd(4'hC, 8'h81, "R10 read busy");
        finish_rd(16'h1234, "R5 fetch1");
        flags(1, 1, "R7 len 1 to 0");
        host_rd(4'hA, 8'h6E, "R5 fetched byte");
        finish_rd(16'h1235, "R7 fetch2");
        flags(0, 1, "R7 read at zero");

        // R8: latch mode with port 0
        host_wr(4'h8, 8'h00);
        host_wr(4'h9, 8'h00);
        host_wr(4'hD, 8'h1E);
        host_rd(4'hC, 8'h00, "R8 end cleared");
        host_rd(4'hA, 8'h6F, "R5 second fetched byte");
        finish_rd(16'h1236, "R8 fetch latched");
        flags(0, 0, "R8 read latched");
        host_wr(4'h9, 8'h90);
        host_wr(4'hA, 8'h11);
        finish_wr(16'h1234, 8'h11, "R8 write latched 9000");
        flags(0, 0, "R8 length follows port");
        host_wr(4'h9, 8'h00);
        host_wr(4'hA, 8'h22);
        finish_wr(16'h1235, 8'h22, "R8 write latched 0");
        flags(1, 0, "R8 end held clear");

        // R6 R7: unlatch with length 2
        host_wr(4'h8, 8'h02);
        host_wr(4'hD, 8'h0E);
        host_rd(4'hA, 8'h6C, "R5 third fetched byte");
        finish_rd(16'h1237, "R7 len 2 to 1");
        flags(1, 0, "R7 nonzero");
        host_wr(4'hA, 8'h33);
        finish_wr(16'h1236, 8'h33, "R6 len 1 to 2");
        flags(1, 0, "R6 no end");
        host_rd(4'hA, 8'h6D, "R5 fetch 4");
        finish_rd(16'h1238, "R7 len 2 to 1b");
        host_rd(4'hA, mem_model(16'h1238), "R5 fetch 5");
        finish_rd(16'h1239, "R7 len 1 to 0b");
        flags(1, 0, "R6 increment seen");
        host_rd(4'hA, mem_model(16'h1239), "R5 fetch 6");
        finish_rd(16'h123A, "R7 empty");
        flags(0, 1, "R7 empty flags");

        // R2 R3 other offset variants
        host_wr(4'hD, 8'h00);
        host_wr(4'h8, 8'h00);
        host_wr(4'h9, 8'h40);
        host_wr(4'hD, 8'h0B);
        chk("R2 write ptr exact", {16'h0, mem_wr_addr}, 32'h4000);
        chk("R3 read ptr early", {16'h0, mem_rd_addr}, 32'h3FFF);

        // R9 clear
        host_wr(4'hA, 8'h44);
        host_wr(4'hD, 8'h8B);
        chk("R9 wr_req", {31'h0, mem_wr_req}, 0);
        chk("R9 wptr", {16'h0, mem_wr_addr}, 0);
        chk("R9 rptr", {16'h0, mem_rd_addr}, 0);
        flags(0, 0, "R9 flags");
        host_rd(4'hC, 8'h00, "R9 status");
        host_wr(4'hD, 8'h0B);
        host_wr(4'hA, 8'h55);
        finish_wr(16'h0000, 8'h55, "R9 write after clear");
        flags(1, 1, "R9 length zero");

        // R10 R11
        playing = 1'b1;
        host_rd(4'hC, 8'h09, "R10 playing");
        host_wr(4'hE, 8'h07);
        host_rd(4'hE, 8'h07, "R11 rate readback");
        chk("R11 rate_cfg", {24'h0, rate_cfg}, 32'h07);
        host_rd(4'hF, 8'h00, "R11 unmapped");
        host_rd(4'hB, 8'h00, "R11 unmapped B");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule